// File: doc/BRIEF.md
# Write-Through Data Cache with Store Queue

This block is a small direct-mapped data cache with a write-through policy. A queue of pending stores sits between the cache and a slow word-wide memory port. A processor store updates the cached word when its line is present and is always appended to the queue. The processor does not wait for memory while the queue has room. A drain engine empties the queue to memory, oldest entry first, one write per memory handshake. Lines are never dirty, so replacing a line never writes anything back.

A load that hits returns its word one cycle after it is accepted. A load that misses holds the processor stalled while two things happen in turn. First, every queued store is written out. Then the line is fetched from memory word by word, in ascending order. The load is accepted once the fetched line is in place, so a read can never see memory that is older than a store still waiting in the queue. A store that misses does not allocate a line.

Top module: `wt_cache_top`

## Requirements
- R1: Reset clears every line to invalid. While reset is applied and afterwards with no request, `stall_o`, `rsp_valid_o` and `mem_req_o` are low.
- R2: A load that hits is accepted in the cycle it is presented. `rsp_valid_o` is high in the next cycle only, with the cached word, and no memory request is made. `rsp_valid_o` never follows a store.
- R3: Each accepted store produces exactly one memory write with the same address and data. Writes leave in the order in which the stores were accepted.
- R4: A store to a word whose line is cached updates that word, so a later load returns the new value without any memory read.
- R5: A store that misses does not allocate a line, and it does not disturb the line held at that index.
- R6: While the queue holds its full four entries, a presented store raises `stall_o` in that same cycle. The store is accepted in the cycle right after the memory acknowledge that frees an entry.
- R7: On a load miss, all queued writes are acknowledged before the first read is issued. The line is then read as four words from offset 0 upward, and the response carries the newest stored value of the loaded word.
- R8: The memory port has at most one request outstanding. Once raised, `mem_req_o` stays high with stable `mem_we_o`, `mem_addr_o` and `mem_wdata_o` until the cycle `mem_ack_i` is seen.
- R9: Replacing a line on a read miss causes no memory write.
- R10: At default parameters the word address is split as offset [1:0], line index [4:2] and tag [15:5]. Two addresses with equal index and different tags evict each other.
- R11: A store presented while the queue has room is accepted in that cycle, even while a memory write is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request present; held while stalled |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 16 | Word address |
| req_wdata_i | input | 32 | Store data |
| stall_o | output | 1 | Request not accepted this cycle |
| rsp_valid_o | output | 1 | Load data valid |
| rsp_rdata_o | output | 32 | Load data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Request completed this cycle; read data valid |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
The hardest case to reach from the ports is a load miss that arrives while the queue still holds several stores, one of them to the very word being loaded. In that case the order of drain and fetch decides whether stale data comes back. The bench slows the memory responder to a fixed long latency and issues stores to uncached addresses. It then loads one of them at once and checks two things: that no read reaches the port while an expected write is still outstanding, and that the returned word is the stored one. A similar slowed run fills the queue to expose the full-queue stall and the exact cycle of release.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_FILL  = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o     = (cnt_q == '0);
  assign full_o      = (cnt_q == CNT_W'(DEPTH));
  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_ptr_q] <= push_addr_i;
      data_q[wr_ptr_q] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);  // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);  // R3
endmodule

// File: rtl/wtc_lines.sv
module wtc_lines #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int LINES = 8,
  parameter int WORDS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] lk_addr_i,
  output logic          hit_o,
  output logic [DW-1:0] rd_data_o,
  input  logic          st_we_i,
  input  logic [DW-1:0] st_data_i,
  input  logic          fill_we_i,
  input  logic          fill_last_i,
  input  logic [AW-1:0] fill_addr_i,
  input  logic [DW-1:0] fill_data_i
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = AW - IDX_W - OFF_W;

  logic             valid_q [LINES];
  logic [TAG_W-1:0] tag_q   [LINES];
  logic [DW-1:0]    data_q  [LINES][WORDS];

  logic [OFF_W-1:0] lk_off, f_off;
  logic [IDX_W-1:0] lk_idx, f_idx;
  logic [TAG_W-1:0] lk_tag, f_tag;

  assign lk_off = lk_addr_i[OFF_W-1:0];
  assign lk_idx = lk_addr_i[OFF_W +: IDX_W];
  assign lk_tag = lk_addr_i[AW-1 -: TAG_W];
  assign f_off  = fill_addr_i[OFF_W-1:0];
  assign f_idx  = fill_addr_i[OFF_W +: IDX_W];
  assign f_tag  = fill_addr_i[AW-1 -: TAG_W];

  assign hit_o     = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign rd_data_o = data_q[lk_idx][lk_off];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    // line is invalid while words are being replaced, valid with the last word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[l] <= 1'b0;
        tag_q[l]   <= '0;
      end else if (fill_we_i && (f_idx == IDX_W'(l))) begin
        valid_q[l] <= fill_last_i;
        tag_q[l]   <= f_tag;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_we_i)
      data_q[f_idx][f_off] <= fill_data_i;
    else if (st_we_i && hit_o)
      data_q[lk_idx][lk_off] <= st_data_i;
  end

  AST_NO_FILL_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_we_i |-> !st_we_i);  // R7
endmodule

// File: rtl/wtc_mem_ctrl.sv
module wtc_mem_ctrl
  import wtc_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int WORDS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 miss_i,
  input  logic [AW-$clog2(WORDS)-1:0] miss_blk_i,
  input  logic                 wb_empty_i,
  input  logic [AW-1:0]        wb_addr_i,
  input  logic [DW-1:0]        wb_data_i,
  output logic                 wb_pop_o,
  output logic                 busy_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [AW-1:0]        mem_addr_o,
  output logic [DW-1:0]        mem_wdata_o,
  input  logic                 mem_ack_i,
  input  logic [DW-1:0]        mem_rdata_i,
  output logic                 fill_we_o,
  output logic                 fill_last_o,
  output logic [AW-1:0]        fill_addr_o,
  output logic [DW-1:0]        fill_data_o
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int BLK_W = AW - OFF_W;

  ctrl_state_e      state_q;
  logic [BLK_W-1:0] blk_q;
  logic [OFF_W-1:0] cnt_q;
  logic             filling;

  assign filling     = (state_q == ST_FILL);
  assign busy_o      = (state_q != ST_IDLE);
  assign fill_addr_o = {blk_q, cnt_q};
  assign fill_data_o = mem_rdata_i;
  assign fill_we_o   = filling && mem_ack_i;
  assign fill_last_o = (cnt_q == OFF_W'(WORDS - 1));

  // fetch owns the port only after the queue is empty
  always_comb begin
    mem_req_o   = filling ? 1'b1 : !wb_empty_i;
    mem_we_o    = !filling;
    mem_addr_o  = filling ? fill_addr_o : wb_addr_i;
    mem_wdata_o = wb_data_i;
    wb_pop_o    = !filling && !wb_empty_i && mem_ack_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      blk_q   <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (miss_i) begin
          state_q <= ST_DRAIN;
          blk_q   <= miss_blk_i;
        end
        ST_DRAIN: if (wb_empty_i) begin
          state_q <= ST_FILL;
          cnt_q   <= '0;
        end
        ST_FILL: if (mem_ack_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (fill_last_o) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_FETCH_AFTER_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> wb_empty_i);  // R7
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)
                                   && (!mem_we_o || $stable(mem_wdata_o))));  // R8
  AST_NO_POP_IN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filling |-> !wb_pop_o);  // R9
endmodule

// File: rtl/wt_cache_top.sv
module wt_cache_top #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int LINES    = 8,
  parameter int WORDS    = 4,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              stall_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int OFF_W = $clog2(WORDS);

  logic              hit, busy, accept, push, miss_start;
  logic              wb_empty, wb_full, wb_pop;
  logic [ADDR_W-1:0] wb_addr, fill_addr;
  logic [DATA_W-1:0] wb_data, fill_data, rd_data;
  logic              fill_we, fill_last;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  assign stall_o    = req_valid_i && (busy || (req_we_i ? wb_full : !hit));
  assign accept     = req_valid_i && !stall_o;
  assign push       = accept && req_we_i;
  assign miss_start = req_valid_i && !req_we_i && !hit && !busy;

  wtc_wbuf #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_addr_i (req_addr_i),
    .push_data_i (req_wdata_i),
    .pop_i       (wb_pop),
    .head_addr_o (wb_addr),
    .head_data_o (wb_data),
    .empty_o     (wb_empty),
    .full_o      (wb_full)
  );

  wtc_lines #(.AW(ADDR_W), .DW(DATA_W), .LINES(LINES), .WORDS(WORDS)) u_lines (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_addr_i   (req_addr_i),
    .hit_o       (hit),
    .rd_data_o   (rd_data),
    .st_we_i     (push),
    .st_data_i   (req_wdata_i),
    .fill_we_i   (fill_we),
    .fill_last_i (fill_last),
    .fill_addr_i (fill_addr),
    .fill_data_i (fill_data)
  );

  wtc_mem_ctrl #(.AW(ADDR_W), .DW(DATA_W), .WORDS(WORDS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .miss_i      (miss_start),
    .miss_blk_i  (req_addr_i[ADDR_W-1:OFF_W]),
    .wb_empty_i  (wb_empty),
    .wb_addr_i   (wb_addr),
    .wb_data_i   (wb_data),
    .wb_pop_o    (wb_pop),
    .busy_o      (busy),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .fill_we_o   (fill_we),
    .fill_last_o (fill_last),
    .fill_addr_o (fill_addr),
    .fill_data_o (fill_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= accept && !req_we_i;
      if (accept && !req_we_i) rsp_data_q <= rd_data;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_data_q;

  AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_we_i && wb_full) |-> stall_o);  // R6
  AST_RSP_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i && !req_we_i && !stall_o));  // R2
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && busy) |-> stall_o);  // R7
endmodule

// File: tb/tb_wt_cache_top.sv
module tb_wt_cache_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid_i, req_we_i;
  logic [15:0] req_addr_i;
  logic [31:0] req_wdata_i;
  logic        stall_o, rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [15:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic        mem_ack_i;
  logic [31:0] mem_rdata_i;

  wt_cache_top dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid_i), .req_we_i(req_we_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .stall_o(stall_o), .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  int tick = 0;
  always @(posedge clk) tick++;

  logic [31:0] ref_mem [256];
  logic [31:0] mem_model [256];
  logic [15:0] wq_addr [2048];
  logic [31:0] wq_data [2048];
  int wq_h = 0, wq_t = 0;
  logic [15:0] rd_log [4096];
  int rd_cnt = 0;
  int last_wack_edge = -10;
  int slow = 0;
  logic        cm_valid [8];
  logic [10:0] cm_tag [8];

  function automatic logic [31:0] init_word(input int a);
    return {16'hC0DE, 16'(a * 13 + 7)};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", rq, act, exp, $time);
    end
  endtask

  // memory responder: random latency, checks handshake and write order
  bit          m_busy = 0;
  int          m_wait = 0;
  logic        l_we;
  logic [15:0] l_addr;
  logic [31:0] l_data;
  initial begin
    mem_ack_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk); #1;
      mem_ack_i = 1'b0;
      if (m_busy) begin
        if (!mem_req_o || mem_we_o != l_we || mem_addr_o != l_addr || (l_we && mem_wdata_o != l_data))
          chk(0, "R8", {31'd0, mem_req_o, mem_addr_o}, {32'd1, l_addr});
      end else if (rst_n && mem_req_o) begin
        m_busy = 1; l_we = mem_we_o; l_addr = mem_addr_o; l_data = mem_wdata_o;
        m_wait = (slow != 0) ? slow : int'($urandom_range(0, 3));
      end
      if (m_busy) begin
        if (m_wait == 0) begin
          mem_ack_i = 1'b1;
          m_busy = 0;
          if (l_we) begin
            chk(wq_h < wq_t, "R9", 64'(wq_t - wq_h), 64'd1);
            if (wq_h < wq_t) begin
              chk(l_addr == wq_addr[wq_h] && l_data == wq_data[wq_h], "R3",
                  {l_addr, l_data}, {wq_addr[wq_h], wq_data[wq_h]});
              wq_h++;
            end
            mem_model[l_addr[7:0]] = l_data;
            last_wack_edge = tick + 1;
          end else begin
            chk(wq_h == wq_t, "R7", 64'(wq_t - wq_h), 64'd0);
            mem_rdata_i = mem_model[l_addr[7:0]];
            rd_log[rd_cnt] = l_addr;
            rd_cnt++;
          end
        end else m_wait--;
      end
    end
  end

  // mode: 0 none, 1 must be accepted at once, 2 must stall first
  task automatic do_store(input logic [15:0] a, input logic [31:0] d, input int mode);
    int acc;
    @(negedge clk);
    req_valid_i = 1; req_we_i = 1; req_addr_i = a; req_wdata_i = d;
    #2;
    if (mode == 1) chk(!stall_o, "R11", stall_o, 0);
    if (mode == 2) chk(stall_o, "R6", stall_o, 1);
    while (stall_o) begin @(negedge clk); #2; end
    acc = tick + 1;
    if (mode == 2) chk(acc == last_wack_edge + 1, "R6", acc, last_wack_edge + 1);
    @(posedge clk);
    wq_addr[wq_t] = a; wq_data[wq_t] = d; wq_t++;
    ref_mem[a[7:0]] = d;
    #1 req_valid_i = 0;
  endtask

  task automatic do_load(input logic [15:0] a, input string rq);
    int r0, nrd;
    bit miss;
    miss = !cm_valid[a[4:2]] || cm_tag[a[4:2]] != a[15:5];
    r0 = rd_cnt;
    @(negedge clk);
    req_valid_i = 1; req_we_i = 0; req_addr_i = a; req_wdata_i = '0;
    #2;
    while (stall_o) begin @(negedge clk); #2; end
    @(posedge clk);
    #1 req_valid_i = 0;
    @(negedge clk); #2;
    chk(rsp_valid_o == 1'b1, rq, rsp_valid_o, 1);
    chk(rsp_rdata_o == ref_mem[a[7:0]], rq, rsp_rdata_o, ref_mem[a[7:0]]);
    nrd = rd_cnt - r0;
    chk(nrd == (miss ? 4 : 0), miss ? "R10" : "R2", nrd, miss ? 4 : 0);
    if (miss) begin
      for (int k = 0; k < 4 && k < nrd; k++)
        chk(rd_log[r0 + k] == {a[15:2], 2'(k)}, "R7", rd_log[r0 + k], {a[15:2], 2'(k)});
    end
    cm_valid[a[4:2]] = 1; cm_tag[a[4:2]] = a[15:5];
    @(negedge clk); #2;
    chk(!rsp_valid_o, "R2", rsp_valid_o, 0);
  endtask

  task automatic wait_idle();
    while (wq_h != wq_t || m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin ref_mem[i] = init_word(i); mem_model[i] = init_word(i); end
    for (int i = 0; i < 8; i++) begin cm_valid[i] = 0; cm_tag[i] = '0; end
    rst_n = 0; req_valid_i = 0; req_we_i = 0; req_addr_i = '0; req_wdata_i = '0;
    repeat (3) @(negedge clk);
    chk(!stall_o && !rsp_valid_o && !mem_req_o, "R1", {stall_o, rsp_valid_o, mem_req_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk); #2;
    chk(!stall_o && !rsp_valid_o && !mem_req_o, "R1", {stall_o, rsp_valid_o, mem_req_o}, 0);

    // miss then hit on the same line
    do_load(16'h0002, "R7");
    do_load(16'h0001, "R2");
    // store hit updates the line
    do_store(16'h0001, 32'h1111_AAAA, 1);
    do_load(16'h0001, "R4");
    // store miss: no allocate, resident line untouched
    do_store(16'h0040, 32'h2222_BBBB, 1);
    do_load(16'h0000, "R5");
    do_load(16'h0040, "R5");
    // conflict on index 0
    do_load(16'h0020, "R10");
    do_load(16'h0043, "R10");
    wait_idle();

    // full queue with slow memory
    slow = 10;
    do_store(16'h0080, 32'h8000_0001, 1);
    do_store(16'h0081, 32'h8000_0002, 1);
    do_store(16'h0082, 32'h8000_0003, 1);
    do_store(16'h0083, 32'h8000_0004, 1);
    do_store(16'h0084, 32'h8000_0005, 2);
    wait_idle();

    // miss with pending stores to the loaded word
    slow = 6;
    do_store(16'h00A5, 32'hA5A5_0001, 1);
    do_store(16'h00C6, 32'hC6C6_0002, 1);
    do_store(16'h00A5, 32'hA5A5_0003, 1);
    do_load(16'h00A5, "R7");
    wait_idle();
    slow = 0;

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      a = 16'($urandom_range(0, 127));
      if ($urandom_range(0, 1) == 0) do_store(a, $urandom(), 0);
      else do_load(a, "R7");
    end
    wait_idle();
    for (int i = 0; i < 256; i++)
      if (mem_model[i] != ref_mem[i]) chk(0, "R3", mem_model[i], ref_mem[i]);
    chk(wq_h == wq_t, "R3", wq_h, wq_t);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule